// File: doc/BRIEF.md
# Security-Gated Interrupt State Word

This block keeps the enable, pending and active state of thirty-two shared peripheral interrupts that together form one word of a larger interrupt map. Software reaches the state through a small word-addressed register port. Each bitmap has a set view and a clear view, and every access carries a secure flag. Unless the block runs in single-security mode, a non-secure access sees and changes only the bits that the per-interrupt group bitmap marks as non-secure. The 2-bit per-interrupt access field can extend that reach to further bits, in graded steps that depend on which view is used.

The block also samples the thirty-two interrupt input lines. It keeps a pending latch that a rising edge sets on any line configured as edge-triggered. A read of pending shows that latch merged with the current level of every level-triggered line. The parameter `WORD_BASE` gives the interrupt ID of bit 0. A word that lies below the shared range, or beyond the implemented interrupt count `NUM_IRQ`, is inert.

A one-cycle update pulse tells downstream arbitration that stored state has changed.

Top module: `irq_state_bank`

## Requirements
- R1: After reset, every stored bit is zero: single-security flag, group, access fields, edge configuration, enable, pending latch and active. `rd_data` and `upd` are also zero.
- R2: The registers are word-addressed: 4/5 enable set/clear, 6/7 pending set/clear, 8/9 active set/clear. A write to a set view sets each bit written as 1. A write to a clear view clears each bit written as 1. Bits written as 0 are unchanged. Both views of a bitmap read the same value.
- R3: `rd_data` is registered. It holds the value of the register at `addr` as sampled on the previous clock edge. That value is the state from before any write in the same cycle.
- R4: An access is restricted when `secure` is 0 and the single-security flag is 0. A restricted access reaches the bits whose group bit is 1, plus further bits that depend on the view. Pending-set reads and writes add the bits whose access field is 1 or more. Pending-clear reads and writes, and active reads, add the bits whose field is 2 or more. Enable reads and writes, active writes and configuration accesses use the group bits only. An access that is not restricted reaches all 32 bits.
- R5: The group register is at address 1. A restricted access reads it as 0 and cannot write it. The access fields are at address 2 (interrupts 0-15) and address 3 (interrupts 16-31), with the field of interrupt i at bits [2(i mod 16)+1 : 2(i mod 16)]. Only a secure access can read or write them, and only while the single-security flag is 0. Any other access reads 0 and cannot write them.
- R6: A pending read returns (latch OR (line level AND NOT edge flag)), masked as in R4. A level-triggered line therefore shows pending while it is high.
- R7: A 0-to-1 change of an input line whose edge flag is 1 sets that pending latch. A rising level-triggered line does not set the latch. A line that stays high does not set it again.
- R8: When an edge sets a pending bit in the same cycle that a pending-clear write clears that bit, the bit ends up set.
- R9: Configuration is at address 10 (interrupts 0-15) and address 11 (interrupts 16-31). The edge flag of interrupt i is at bit 2(i mod 16)+1. Even bits read as zero and are not stored. Writes are masked with the group-only mask of R4.
- R10: The single-security flag is bit 0 of address 0 and is readable by any access. Only a secure write of 1 sets it. Once set, it stays set until reset.
- R11: `upd` is high in exactly the cycle after a clock edge that changed any stored bit (listed in R1). Writes that change nothing, and changes of line level alone, do not raise it.
- R12: When `WORD_BASE` is below 32 or at or above `NUM_IRQ`, every address except 0 reads zero and ignores writes, and line edges set nothing.
- R13: Addresses 12 to 15 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 32 | Interrupt input levels, bit i is interrupt WORD_BASE+i |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 32 | Write data |
| secure | input | 1 | Security attribute of the access (1 = secure) |
| rd_data | output | 32 | Read data for the address of the previous cycle |
| upd | output | 1 | One-cycle pulse after any stored state change |

## Verification
The pending latch has two sources: a rising edge on an edge-configured line and a software clear write. Both can land on the same clock edge. The bench raises one edge-configured line at the same moment that a pending-clear write targets that interrupt and a second, already latched interrupt. It then reads the latch back. Only the bit with the edge may survive, which shows that the edge takes priority and that the clear still acts on the other bit.

// File: rtl/isb_pkg.sv
package isb_pkg;
    localparam int ADDR_W = 4;
    localparam int WORD_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        RG_CTRL   = 4'd0,
        RG_GROUP  = 4'd1,
        RG_ACC_LO = 4'd2,
        RG_ACC_HI = 4'd3,
        RG_EN_SET = 4'd4,
        RG_EN_CLR = 4'd5,
        RG_PD_SET = 4'd6,
        RG_PD_CLR = 4'd7,
        RG_AC_SET = 4'd8,
        RG_AC_CLR = 4'd9,
        RG_CFG_LO = 4'd10,
        RG_CFG_HI = 4'd11
    } reg_sel_e;

    typedef struct packed {
        logic                  ds;
        logic [WORD_W-1:0]     grp;
        logic [2*WORD_W-1:0]   acc;
        logic [WORD_W-1:0]     en;
        logic [WORD_W-1:0]     pend;
        logic [WORD_W-1:0]     act;
        logic [WORD_W-1:0]     edg;
        logic [WORD_W-1:0]     line;
        logic                  upd;
        logic [WORD_W-1:0]     rdata;
    } isb_state_t;
endpackage

// File: rtl/isb_mask_gen.sv
module isb_mask_gen #(
    parameter int N = 32
) (
    input  logic             restrict_i,
    input  logic [N-1:0]     group_i,
    input  logic [2*N-1:0]   acc_i,
    output logic [N-1:0]     m_grp_o,
    output logic [N-1:0]     m_ge1_o,
    output logic [N-1:0]     m_ge2_o
);
    logic [N-1:0] lvl1;
    logic [N-1:0] lvl2;

    // Per-interrupt decode of the graded access field
    for (genvar i = 0; i < N; i++) begin : g_field
        assign lvl1[i] = |acc_i[2*i +: 2];
        assign lvl2[i] = acc_i[2*i+1];
    end

    assign m_grp_o = restrict_i ? group_i          : '1;
    assign m_ge1_o = restrict_i ? (group_i | lvl1) : '1;
    assign m_ge2_o = restrict_i ? (group_i | lvl2) : '1;
endmodule

// File: rtl/isb_cfg_pack.sv
module isb_cfg_pack #(
    parameter int N = 32
) (
    input  logic [N-1:0]   edge_i,
    input  logic [N-1:0]   wdata_i,
    output logic [N-1:0]   rd_lo_o,
    output logic [N-1:0]   rd_hi_o,
    output logic [N/2-1:0] flags_o
);
    localparam int HALF = N / 2;

    logic [HALF-1:0] even_unused;

    // Spread one flag per interrupt into the odd bit of each pair and back
    for (genvar i = 0; i < HALF; i++) begin : g_pair
        assign rd_lo_o[2*i]   = 1'b0;
        assign rd_lo_o[2*i+1] = edge_i[i];
        assign rd_hi_o[2*i]   = 1'b0;
        assign rd_hi_o[2*i+1] = edge_i[HALF+i];
        assign flags_o[i]     = wdata_i[2*i+1];
        assign even_unused[i] = wdata_i[2*i];
    end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import isb_pkg::*;
#(
    parameter int WORD_BASE    = 32,
    parameter int NUM_IRQ      = 64,
    parameter int FIRST_SHARED = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] irq_line,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              secure,
    output logic [WORD_W-1:0] rd_data,
    output logic              upd
);
    localparam int HALF    = WORD_W / 2;
    localparam bit WORD_OK = (WORD_BASE >= FIRST_SHARED) && (WORD_BASE < NUM_IRQ);

    isb_state_t s_q, s_d;

    logic              restrict_ns;
    logic              acc_open;
    logic              reg_ok;
    logic [WORD_W-1:0] m_grp, m_ge1, m_ge2;
    logic [WORD_W-1:0] cfg_rd_lo, cfg_rd_hi;
    logic [HALF-1:0]   cfg_flags;
    logic [WORD_W-1:0] pend_view;
    logic [WORD_W-1:0] sw_set, sw_clr, edge_hit, rv;

    assign restrict_ns = !secure && !s_q.ds;
    assign acc_open    = secure && !s_q.ds;
    assign reg_ok      = WORD_OK || (addr == RG_CTRL);

    isb_mask_gen #(.N(WORD_W)) u_mask (
        .restrict_i (restrict_ns),
        .group_i    (s_q.grp),
        .acc_i      (s_q.acc),
        .m_grp_o    (m_grp),
        .m_ge1_o    (m_ge1),
        .m_ge2_o    (m_ge2)
    );

    isb_cfg_pack #(.N(WORD_W)) u_cfg (
        .edge_i  (s_q.edg & m_grp),
        .wdata_i (wr_data),
        .rd_lo_o (cfg_rd_lo),
        .rd_hi_o (cfg_rd_hi),
        .flags_o (cfg_flags)
    );

    always_comb begin
        s_d       = s_q;
        sw_set    = '0;
        sw_clr    = '0;
        pend_view = s_q.pend | (s_q.line & ~s_q.edg);

        // Read mux, registered into rdata
        case (addr)
            RG_CTRL:   rv = {{(WORD_W-1){1'b0}}, s_q.ds};
            RG_GROUP:  rv = restrict_ns ? '0 : s_q.grp;
            RG_ACC_LO: rv = acc_open ? s_q.acc[WORD_W-1:0] : '0;
            RG_ACC_HI: rv = acc_open ? s_q.acc[2*WORD_W-1:WORD_W] : '0;
            RG_EN_SET,
            RG_EN_CLR: rv = s_q.en & m_grp;
            RG_PD_SET: rv = pend_view & m_ge1;
            RG_PD_CLR: rv = pend_view & m_ge2;
            RG_AC_SET,
            RG_AC_CLR: rv = s_q.act & m_ge2;
            RG_CFG_LO: rv = cfg_rd_lo;
            RG_CFG_HI: rv = cfg_rd_hi;
            default:   rv = '0;
        endcase
        s_d.rdata = reg_ok ? rv : '0;

        // Register writes
        if (wr_en && reg_ok) begin
            case (addr)
                RG_CTRL:   if (acc_open && wr_data[0]) s_d.ds = 1'b1;
                RG_GROUP:  if (!restrict_ns) s_d.grp = wr_data;
                RG_ACC_LO: if (acc_open) s_d.acc[WORD_W-1:0] = wr_data;
                RG_ACC_HI: if (acc_open) s_d.acc[2*WORD_W-1:WORD_W] = wr_data;
                RG_EN_SET: s_d.en = s_q.en | (wr_data & m_grp);
                RG_EN_CLR: s_d.en = s_q.en & ~(wr_data & m_grp);
                RG_PD_SET: sw_set = wr_data & m_ge1;
                RG_PD_CLR: sw_clr = wr_data & m_ge2;
                RG_AC_SET: s_d.act = s_q.act | (wr_data & m_grp);
                RG_AC_CLR: s_d.act = s_q.act & ~(wr_data & m_grp);
                RG_CFG_LO: s_d.edg[HALF-1:0] = (s_q.edg[HALF-1:0] & ~m_grp[HALF-1:0])
                                             | (cfg_flags & m_grp[HALF-1:0]);
                RG_CFG_HI: s_d.edg[WORD_W-1:HALF] = (s_q.edg[WORD_W-1:HALF] & ~m_grp[WORD_W-1:HALF])
                                                  | (cfg_flags & m_grp[WORD_W-1:HALF]);
                default: ;
            endcase
        end

        // Line sampling and edge latch; an edge outranks a same-cycle clear
        s_d.line = irq_line;
        edge_hit = WORD_OK ? (irq_line & ~s_q.line & s_q.edg) : '0;
        s_d.pend = (s_q.pend & ~sw_clr) | sw_set | edge_hit;

        s_d.upd = {s_d.ds, s_d.grp, s_d.acc, s_d.en, s_d.pend, s_d.act, s_d.edg}
               != {s_q.ds, s_q.grp, s_q.acc, s_q.en, s_q.pend, s_q.act, s_q.edg};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.rdata;
    assign upd     = s_q.upd;

    // Observation aliases for the properties below
    logic [WORD_W-1:0]   en_q, pend_q, act_q, edge_q, line_q;
    logic [2*WORD_W-1:0] acc_q;
    logic                ds_q;
    assign en_q   = s_q.en;
    assign pend_q = s_q.pend;
    assign act_q  = s_q.act;
    assign edge_q = s_q.edg;
    assign line_q = s_q.line;
    assign acc_q  = s_q.acc;
    assign ds_q   = s_q.ds;

    // R2: a secure clear write leaves none of the written enable bits set
    a_r2_clear_view: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && secure && addr == RG_EN_CLR) |=> ((en_q & $past(wr_data)) == '0));

    // R5: non-secure writes never reach the access fields
    a_r5_acc_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !secure && (addr == RG_ACC_LO || addr == RG_ACC_HI)) |=> $stable(acc_q));

    // R7 and R8: an edge on an edge-configured line always leaves its latch set
    a_r7_edge_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (WORD_OK && |(irq_line & ~line_q & edge_q))
        |=> ((pend_q & $past(irq_line & ~line_q & edge_q)) == $past(irq_line & ~line_q & edge_q)));

    // R10: the single-security flag never falls outside reset
    a_r10_ds_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ds_q) |-> ds_q);

    // R11: a change of any bitmap is flagged in the cycle it becomes visible
    a_r11_upd_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q != $past(en_q)) || (pend_q != $past(pend_q)) || (act_q != $past(act_q))) |-> upd);

    // R12: an inert word holds no interrupt state
    if (!WORD_OK) begin : g_inert_chk
        a_r12_inert_word: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q == '0) && (pend_q == '0) && (act_q == '0) && (edge_q == '0));
    end
endmodule

// File: tb/test_irq_state_bank.sv
`timescale 1ns/1ps
module test_irq_state_bank;
    localparam logic [3:0] A_CTRL = 4'd0, A_GROUP = 4'd1, A_ACC_LO = 4'd2, A_ACC_HI = 4'd3,
                           A_EN_S = 4'd4, A_EN_C = 4'd5, A_PD_S = 4'd6, A_PD_C = 4'd7,
                           A_AC_S = 4'd8, A_AC_C = 4'd9, A_CFG_LO = 4'd10, A_CFG_HI = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_line = '0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        secure = 1'b1;
    logic [31:0] rd_data, rd_b;
    logic        upd, upd_b;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_state_bank i_irq_state_bank (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .secure(secure), .rd_data(rd_data), .upd(upd));

    irq_state_bank #(.WORD_BASE(64)) i_irq_state_bank_oob (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .secure(secure), .rd_data(rd_b), .upd(upd_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; irq_line = '0; addr = '0; secure = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        addr = a; wr_data = d; secure = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic s, output logic [31:0] v);
        @(negedge clk);
        addr = a; secure = s; wr_en = 1'b0;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 upd after reset", {31'b0, upd}, 32'h0);
        for (int a = 0; a < 12; a++) begin
            rd(a[3:0], 1'b1, v);
            chk("R1 register zero after reset", v, 32'h0);
        end
        wr(4'd12, 32'hFFFF_FFFF, 1'b1);
        chk("R13 write to unused address no update", {31'b0, upd}, 32'h0);
        for (int a = 12; a < 16; a++) begin
            rd(a[3:0], 1'b1, v);
            chk("R13 unused address reads zero", v, 32'h0);
        end
    endtask

    task automatic t_views();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        addr = A_EN_S; wr_data = 32'h5; secure = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 read shows state before same-cycle write", rd_data, 32'h0);
        chk("R11 upd after enable change", {31'b0, upd}, 32'h1);
        @(negedge clk);
        chk("R3 read shows new state next cycle", rd_data, 32'h5);
        chk("R11 upd lasts one cycle", {31'b0, upd}, 32'h0);
        wr(A_EN_S, 32'h30, 1'b1);
        rd(A_EN_C, 1'b1, v);
        chk("R2 clear view reads same bitmap", v, 32'h35);
        wr(A_EN_C, 32'h14, 1'b1);
        rd(A_EN_S, 1'b1, v);
        chk("R2 clear view clears ones only", v, 32'h21);
        wr(A_EN_S, 32'h1, 1'b1);
        chk("R11 no upd when set changes nothing", {31'b0, upd}, 32'h0);
        wr(A_EN_C, 32'h0, 1'b1);
        chk("R11 no upd when clear writes zeros", {31'b0, upd}, 32'h0);
        rd(A_EN_S, 1'b1, v);
        chk("R2 zero write leaves bitmap", v, 32'h21);
        wr(A_AC_S, 32'h8000_0001, 1'b1);
        wr(A_AC_C, 32'h1, 1'b1);
        rd(A_AC_S, 1'b1, v);
        chk("R2 active set and clear", v, 32'h8000_0000);
        wr(A_PD_S, 32'hF0, 1'b1);
        wr(A_PD_C, 32'h30, 1'b1);
        rd(A_PD_S, 1'b1, v);
        chk("R2 pending set and clear", v, 32'hC0);
    endtask

    task automatic t_masking();
        logic [31:0] v;
        do_reset();
        wr(A_GROUP, 32'hFF, 1'b1);
        wr(A_ACC_LO, 32'h0039_0000, 1'b1);
        wr(A_ACC_HI, 32'h0000_0100, 1'b1);
        rd(A_GROUP, 1'b0, v);
        chk("R5 restricted group read is zero", v, 32'h0);
        wr(A_ACC_LO, 32'h0, 1'b0);
        rd(A_ACC_LO, 1'b1, v);
        chk("R5 restricted access-field write ignored", v, 32'h0039_0000);
        rd(A_ACC_LO, 1'b0, v);
        chk("R5 restricted access-field read zero", v, 32'h0);
        wr(A_EN_S, 32'hFFFF_FFFF, 1'b0);
        rd(A_EN_S, 1'b1, v);
        chk("R4 enable write uses group only", v, 32'hFF);
        wr(A_PD_S, 32'hFFFF_FFFF, 1'b0);
        rd(A_PD_S, 1'b1, v);
        chk("R4 pending set needs field>=1", v, 32'h0010_07FF);
        rd(A_PD_S, 1'b0, v);
        chk("R4 restricted pending-set read", v, 32'h0010_07FF);
        rd(A_PD_C, 1'b0, v);
        chk("R4 restricted pending-clear read needs field>=2", v, 32'h6FF);
        wr(A_PD_C, 32'hFFFF_FFFF, 1'b0);
        rd(A_PD_S, 1'b1, v);
        chk("R4 restricted pending clear needs field>=2", v, 32'h0010_0100);
        wr(A_AC_S, 32'hFFFF_FFFF, 1'b0);
        wr(A_AC_S, 32'h300, 1'b1);
        rd(A_AC_C, 1'b0, v);
        chk("R4 restricted active read needs field>=2", v, 32'h2FF);
        wr(A_AC_C, 32'hFFFF_FFFF, 1'b0);
        rd(A_AC_S, 1'b1, v);
        chk("R4 restricted active write uses group only", v, 32'h300);
        wr(A_CFG_LO, 32'hFFFF_FFFF, 1'b0);
        rd(A_CFG_LO, 1'b1, v);
        chk("R9 restricted config write masked by group", v, 32'h0000_AAAA);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        do_reset();
        wr(A_CFG_LO, 32'hFFFF_FFFF, 1'b1);
        rd(A_CFG_LO, 1'b1, v);
        chk("R9 even config bits read zero", v, 32'hAAAA_AAAA);
        wr(A_CFG_LO, 32'h2, 1'b1);
        wr(A_CFG_HI, 32'h8, 1'b1);
        rd(A_CFG_HI, 1'b1, v);
        chk("R9 upper config word", v, 32'h8);
        @(negedge clk); irq_line = 32'h3;
        rd(A_PD_S, 1'b1, v);
        chk("R6 level line and edge latch visible", v, 32'h3);
        @(negedge clk); irq_line = 32'h0;
        rd(A_PD_S, 1'b1, v);
        chk("R7 edge latch holds after line falls", v, 32'h1);
        @(negedge clk); irq_line = 32'h2;
        @(negedge clk); irq_line = 32'h0;
        rd(A_PD_S, 1'b1, v);
        chk("R7 level rise does not latch", v, 32'h1);
        wr(A_PD_C, 32'h1, 1'b1);
        @(negedge clk); irq_line = 32'h1;
        rd(A_PD_S, 1'b1, v);
        chk("R7 new edge latches", v, 32'h1);
        wr(A_PD_C, 32'h1, 1'b1);
        repeat (3) @(negedge clk);
        rd(A_PD_S, 1'b1, v);
        chk("R7 steady high does not relatch", v, 32'h0);
        @(negedge clk); irq_line = 32'h0002_0000;
        @(negedge clk); irq_line = 32'h0;
        rd(A_PD_S, 1'b1, v);
        chk("R9 upper config flag position", v, 32'h0002_0000);
    endtask

    task automatic t_race();
        logic [31:0] v;
        do_reset();
        wr(A_CFG_LO, 32'h22, 1'b1);
        wr(A_PD_S, 32'h4, 1'b1);
        @(negedge clk);
        irq_line = 32'h1; addr = A_PD_C; wr_data = 32'h5; secure = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_PD_S, 1'b1, v);
        chk("R8 edge wins over same-cycle clear", v, 32'h1);
    endtask

    task automatic t_single_sec();
        logic [31:0] v;
        do_reset();
        wr(A_ACC_LO, 32'h0039_0000, 1'b1);
        wr(A_EN_S, 32'hFFFF_FFFF, 1'b0);
        rd(A_EN_S, 1'b1, v);
        chk("R4 restricted access without group reaches nothing", v, 32'h0);
        wr(A_CTRL, 32'h1, 1'b0);
        rd(A_CTRL, 1'b0, v);
        chk("R10 non-secure cannot set single-security", v, 32'h0);
        wr(A_CTRL, 32'h1, 1'b1);
        wr(A_CTRL, 32'h0, 1'b1);
        rd(A_CTRL, 1'b0, v);
        chk("R10 single-security sticky", v, 32'h1);
        wr(A_EN_S, 32'hF, 1'b0);
        rd(A_EN_S, 1'b0, v);
        chk("R4 single-security gives full mask", v, 32'hF);
        wr(A_GROUP, 32'h5, 1'b0);
        rd(A_GROUP, 1'b0, v);
        chk("R5 group writable in single-security", v, 32'h5);
        rd(A_ACC_LO, 1'b1, v);
        chk("R5 access fields hidden in single-security", v, 32'h0);
    endtask

    task automatic t_oob();
        do_reset();
        wr(A_EN_S, 32'hFFFF_FFFF, 1'b1);
        chk("R12 inert word no upd", {31'b0, upd_b}, 32'h0);
        wr(A_CFG_LO, 32'hFFFF_FFFF, 1'b1);
        @(negedge clk); addr = A_EN_S;
        @(negedge clk);
        chk("R12 inert word enable reads zero", rd_b, 32'h0);
        @(negedge clk); addr = A_CFG_LO;
        @(negedge clk);
        chk("R12 inert word config reads zero", rd_b, 32'h0);
        wr(A_CTRL, 32'h1, 1'b1);
        @(negedge clk); addr = A_CTRL;
        @(negedge clk);
        chk("R12 control still works in inert word", rd_b, 32'h1);
    endtask

    initial begin
        t_reset();
        t_views();
        t_masking();
        t_pending();
        t_race();
        t_single_sec();
        t_oob();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule